// File: doc/BRIEF.md
# Conditional skip operate unit

This unit executes the skip-group operate microinstruction of a 12-bit accumulator machine. From the instruction word, the current accumulator, the link bit and the front-panel switch register, it works out three things: whether the next instruction is skipped, what the accumulator becomes, and whether a halt is requested. A skip moves the 15-bit next-PC forward by one. That value is a 3-bit field above a 12-bit address.

Two forms of the group share one encoding. A single sense bit picks between them. In the OR-sense form the skip is taken when any selected condition holds. In the AND-sense form each selected condition is inverted, and the skip is taken only when every selected condition holds. All results are registered, so they appear one clock after the inputs. An instruction outside the group passes the accumulator and next-PC through unchanged.

Top module: `skip_operate_unit`

## Requirements
- R1: The group is recognised when instr_i[11:9] is 3'b111, instr_i[8] is 1 and instr_i[0] is 0. For any other instruction, acc_o and next_pc_o equal the inputs and halt_o is 0.
- R2: The sense bit is instr_i[3]. When it is 0 (OR sense), instr_i[6] tests acc bit 11 set, instr_i[5] tests acc equal to zero and instr_i[4] tests link set. The skip is taken if any selected test is true.
- R3: When the sense bit is 1 (AND sense), the same three bits test acc bit 11 clear, acc nonzero and link clear. The skip is taken only if every selected test is true.
- R4: With instr_i[6:4] all zero, the AND-sense form always skips and the OR-sense form never skips.
- R5: The skip tests use acc_i as presented, before any clear takes effect.
- R6: instr_i[7] clears the accumulator. instr_i[2] ORs sw_i into the accumulator after the clear, so setting both loads sw_i.
- R7: halt_o is 1 exactly when the registered instruction is in the group and has instr_i[1] set.
- R8: A skip adds one to next_pc_i[11:0], wrapping from 12'hfff to 0. The field bits next_pc_i[14:12] are always kept.
- R9: The outputs are registered with one clock of latency. While rst_ni is low, acc_o, next_pc_o and halt_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link bit |
| sw_i | input | 12 | Switch register |
| next_pc_i | input | 15 | Next-PC: field in [14:12], address in [11:0] |
| acc_o | output | 12 | Updated accumulator |
| next_pc_o | output | 15 | Next-PC, incremented when the skip is taken |
| halt_o | output | 1 | Halt request |

## Verification
The assertions assume that the inputs are stable across each rising clock edge. They also assume that every cycle carries a fresh instruction, so that each registered output can be tied to the inputs one edge earlier. The bench drives all inputs on the falling edge and samples the outputs on the next falling edge, which keeps it within those assumptions. About half the random instruction words are forced into the group, and the sense bit and condition bits are drawn at random. The directed cases cover the address wrap, the empty condition set in both senses, and clear combined with the switch OR.

// File: rtl/skip_op_pkg.sv
package skip_op_pkg;
  localparam int unsigned INSTR_W = 12;
  // bit positions fixed by the instruction encoding
  localparam int unsigned B_GRP    = 8;
  localparam int unsigned B_CLR    = 7;
  localparam int unsigned B_MSB    = 6;
  localparam int unsigned B_ZERO   = 5;
  localparam int unsigned B_LINK   = 4;
  localparam int unsigned B_SENSE  = 3;
  localparam int unsigned B_SWOR   = 2;
  localparam int unsigned B_HALT   = 1;
  localparam int unsigned B_LOW    = 0;
  localparam logic [2:0]  OP_OPR   = 3'b111;

  typedef struct packed {
    logic clr;
    logic t_msb;
    logic t_zero;
    logic t_link;
    logic sense;
    logic sw_or;
    logic halt;
  } skip_ctl_t;
endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval #(
  parameter int unsigned DATA_W = 12
) (
  input  skip_op_pkg::skip_ctl_t ctl_i,
  input  logic [DATA_W-1:0]      acc_i,
  input  logic                   link_i,
  output logic                   skip_o
);
  logic is_neg, is_zero, any_hit;

  assign is_neg  = acc_i[DATA_W-1];
  assign is_zero = (acc_i == '0);
  assign any_hit = (ctl_i.t_msb & is_neg) | (ctl_i.t_zero & is_zero) | (ctl_i.t_link & link_i);
  // AND sense: inverted tests all true == none of the plain tests true
  assign skip_o  = ctl_i.sense ? ~any_hit : any_hit;

  always_comb begin
    if (!(ctl_i.t_msb | ctl_i.t_zero | ctl_i.t_link))
      a_r4_empty_set : assert (skip_o == ctl_i.sense);
  end
endmodule

// File: rtl/acc_update.sv
module acc_update #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              active_i,
  input  logic              clr_i,
  input  logic              sw_or_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] cleared;

  always_comb begin
    cleared = (active_i && clr_i) ? '0 : acc_i;
    acc_o   = (active_i && sw_or_i) ? (cleared | sw_i) : cleared;
  end

  always_comb begin
    if (active_i && clr_i && sw_or_i)
      a_r6_load_sw : assert (acc_o == sw_i);
  end
endmodule

// File: rtl/pc_advance.sv
module pc_advance #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FIELD_W = 3
) (
  input  logic [FIELD_W+DATA_W-1:0] pc_i,
  input  logic                      step_i,
  output logic [FIELD_W+DATA_W-1:0] pc_o
);
  localparam int unsigned PC_W = FIELD_W + DATA_W;
  logic [DATA_W-1:0] addr_nxt;

  assign addr_nxt = pc_i[DATA_W-1:0] + DATA_W'(step_i);
  assign pc_o     = {pc_i[PC_W-1:DATA_W], addr_nxt};

  always_comb begin
    a_r8_field_kept : assert (pc_o[PC_W-1:DATA_W] == pc_i[PC_W-1:DATA_W]);
  end
endmodule

// File: rtl/skip_operate_unit.sv
module skip_operate_unit
  import skip_op_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FIELD_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic [DATA_W-1:0]         acc_i,
  input  logic                      link_i,
  input  logic [DATA_W-1:0]         sw_i,
  input  logic [FIELD_W+DATA_W-1:0] next_pc_i,
  output logic [DATA_W-1:0]         acc_o,
  output logic [FIELD_W+DATA_W-1:0] next_pc_o,
  output logic                      halt_o
);
  localparam int unsigned PC_W = FIELD_W + DATA_W;

  logic              in_grp, skip_raw, do_skip;
  skip_ctl_t         ctl;
  logic [DATA_W-1:0] acc_nxt;
  logic [PC_W-1:0]   pc_nxt;

  assign in_grp = (instr_i[INSTR_W-1:INSTR_W-3] == OP_OPR) & instr_i[B_GRP] & ~instr_i[B_LOW];

  assign ctl = '{clr:    instr_i[B_CLR],
                 t_msb:  instr_i[B_MSB],
                 t_zero: instr_i[B_ZERO],
                 t_link: instr_i[B_LINK],
                 sense:  instr_i[B_SENSE],
                 sw_or:  instr_i[B_SWOR],
                 halt:   instr_i[B_HALT]};

  skip_cond_eval #(.DATA_W(DATA_W)) i_cond (
    .ctl_i (ctl),
    .acc_i (acc_i),
    .link_i(link_i),
    .skip_o(skip_raw)
  );

  assign do_skip = in_grp & skip_raw;

  acc_update #(.DATA_W(DATA_W)) i_acc (
    .active_i(in_grp),
    .clr_i   (ctl.clr),
    .sw_or_i (ctl.sw_or),
    .acc_i   (acc_i),
    .sw_i    (sw_i),
    .acc_o   (acc_nxt)
  );

  pc_advance #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) i_pc (
    .pc_i  (next_pc_i),
    .step_i(do_skip),
    .pc_o  (pc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o     <= '0;
      next_pc_o <= '0;
      halt_o    <= 1'b0;
    end else begin
      acc_o     <= acc_nxt;
      next_pc_o <= pc_nxt;
      halt_o    <= in_grp & ctl.halt;
    end
  end

  a_r1_passthru : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_grp |=> (acc_o == $past(acc_i)) && (next_pc_o == $past(next_pc_i)) && !halt_o);

  a_r7_halt_src : assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(in_grp) && $past(instr_i[B_HALT]));

  a_r8_step_one : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (next_pc_o[DATA_W-1:0] == $past(next_pc_i[DATA_W-1:0])) ||
             (next_pc_o[DATA_W-1:0] == $past(next_pc_i[DATA_W-1:0]) + DATA_W'(1)));

  a_r9_field_reg : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> next_pc_o[PC_W-1:DATA_W] == $past(next_pc_i[PC_W-1:DATA_W]));
endmodule

// File: tb/test_skip_operate_unit.sv
module test_skip_operate_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] instr_i = '0, acc_i = '0, sw_i = '0;
  logic        link_i = 1'b0;
  logic [14:0] next_pc_i = '0;
  logic [11:0] acc_o;
  logic [14:0] next_pc_o;
  logic        halt_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  skip_operate_unit i_skip_operate_unit (
    .clk_i, .rst_ni, .instr_i, .acc_i, .link_i, .sw_i, .next_pc_i,
    .acc_o, .next_pc_o, .halt_o
  );

  function automatic logic [27:0] model(input logic [11:0] ins, input logic [11:0] acc,
                                        input logic lnk, input logic [11:0] sw,
                                        input logic [14:0] pc);
    logic grp, hit, sk, hl;
    logic [11:0] a;
    logic [14:0] p;
    grp = (ins[11:9] == 3'b111) && ins[8] && !ins[0];
    a = acc; p = pc; hl = 1'b0;
    if (grp) begin
      hit = (ins[6] && acc[11]) || (ins[5] && acc == 12'd0) || (ins[4] && lnk);
      sk  = ins[3] ? !hit : hit;
      if (ins[7]) a = 12'd0;
      if (ins[2]) a = a | sw;
      if (sk) p = {pc[14:12], pc[11:0] + 12'd1};
      hl = ins[1];
    end
    return {a, p, hl};
  endfunction

  task automatic check(input string tag, input logic [27:0] got, input logic [27:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got acc=%o pc=%o halt=%b exp acc=%o pc=%o halt=%b", tag,
               got[27:16], got[15:1], got[0], exp[27:16], exp[15:1], exp[0]);
    end
  endtask

  task automatic run(input string tag, input logic [11:0] ins, input logic [11:0] acc,
                     input logic lnk, input logic [11:0] sw, input logic [14:0] pc);
    @(negedge clk_i);
    instr_i = ins; acc_i = acc; link_i = lnk; sw_i = sw; next_pc_i = pc;
    @(negedge clk_i);
    check(tag, {acc_o, next_pc_o, halt_o}, model(ins, acc, lnk, sw, pc));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    instr_i = 12'o7402; acc_i = 12'o7777; sw_i = 12'o5252; next_pc_i = 15'o12345;
    #7;
    check("R9 reset", {acc_o, next_pc_o, halt_o}, 28'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    run("R1 non-group 0401", 12'o7401, 12'o1234, 1'b1, 12'o7777, 15'o30100);
    run("R1 opcode 6", 12'o6402, 12'o0001, 1'b0, 12'o7777, 15'o00100);
    run("R4 OR empty no skip", 12'o7400, 12'o0000, 1'b1, 12'o0, 15'o20010);
    run("R4 AND empty skip", 12'o7410, 12'o4000, 1'b1, 12'o0, 15'o20010);
    run("R2 negative skip", 12'o7500, 12'o4001, 1'b0, 12'o0, 15'o00200);
    run("R2 zero skip", 12'o7440, 12'o0000, 1'b0, 12'o0, 15'o00200);
    run("R2 link skip", 12'o7420, 12'o0003, 1'b1, 12'o0, 15'o00200);
    run("R3 positive nonzero", 12'o7550, 12'o0003, 1'b0, 12'o0, 15'o00200);
    run("R3 link set no skip", 12'o7570, 12'o0003, 1'b1, 12'o0, 15'o00200);
    run("R5 clear after test", 12'o7640, 12'o0000, 1'b0, 12'o0, 15'o00300);
    run("R5 clear then SPA", 12'o7710, 12'o4000, 1'b0, 12'o0, 15'o00300);
    run("R6 clear and sw load", 12'o7604, 12'o1111, 1'b0, 12'o6060, 15'o00400);
    run("R6 sw or", 12'o7404, 12'o1100, 1'b0, 12'o0011, 15'o00400);
    run("R7 halt", 12'o7402, 12'o0, 1'b0, 12'o0, 15'o00500);
    run("R8 wrap", 12'o7410, 12'o0, 1'b0, 12'o0, 15'o77777);
    run("R8 wrap field 3", 12'o7410, 12'o0, 1'b0, 12'o0, 15'o37777);

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] ins;
      ins = 12'($urandom());
      if ($urandom() % 2 == 0) begin
        ins[11:8] = 4'b1111;
        ins[0] = 1'b0;
      end
      run("R2 R3 R6 R7 R8 random", ins, 12'($urandom()), 1'($urandom()),
          12'($urandom()), 15'($urandom()));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule